// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Interface

This block holds the digital control state of a parallel-input converter. It has two double-buffered channels. The code channel is 18 bits wide, with bit 17 as the most significant bit. The range channel is 3 bits wide and picks the analog output range. Each channel has a staging register and an active register. A low-active write strobe loads the staging register of the channel chosen by a select input. An update pulse moves both staging registers into their active registers in the same cycle. The active code and active range are always visible on dedicated outputs.

Each bidirectional pin group is modelled as an input bus, an output bus and an output enable. With the read input high, the update pin stops acting as an update and picks which stage is driven back: the staging register or the active register. An asynchronous low-active clear forces the active code at once to a value set by the active range, and the code register keeps that value after the clear ends. A manual-range strap replaces the range channel with fixed strap inputs, and the range pins then stop responding to writes, updates and reads.

Top module: `dac_regif`

## Requirements
- R1: A high `rst` sampled on a rising edge sets all four registers to zero. After reset, `dac_code` is 0, `dac_span` is 000 and both output enables are low.
- R2: With `wr_n` low, `rd` low and `sel_span` 0, the rising edge loads `data_in` into the code staging register. `dac_code` does not change.
- R3: With `wr_n` low, `rd` low, `sel_span` 1 and `man_span` low, the rising edge loads `span_in` into the range staging register. `dac_span` does not change.
- R4: While `rd` is high, a low `wr_n` changes neither staging register.
- R5: With `rd` low, `upd` high and `clr_n` high, the rising edge copies both staging registers into their active registers, whatever `sel_span` is. The new values appear on `dac_code` and `dac_span` after that edge.
- R6: `data_oe` equals `rd & ~sel_span`. `span_oe` equals `rd & sel_span & ~man_span`. While its enable is high, a port drives its active register if `upd` is high and its staging register if `upd` is low.
- R7: While `rd` is high, `upd` changes neither active register.
- R8: While `clr_n` is low, `dac_code` shows the clear code at once, without waiting for a clock edge, and the code register takes that value on each edge. The clear code follows the active range, with range codes 000 = 0..5 V, 001 = 0..10 V, 010 = ±5 V, 011 = ±10 V, 100 = ±2.5 V, 101 = -2.5..7.5 V, and 110 and 111 treated as 000. Ranges 000, 001, 110 and 111 give 0x00000. Ranges 010, 011 and 100 give 0x20000. Range 101 gives 0x10000. Clear leaves the staging registers unchanged.
- R9: When `clr_n` is low on an edge where an update is requested, neither active register takes the staging value.
- R10: While `man_span` is high, `dac_span` equals `strap_span`. The clear code uses `strap_span`. Range writes and updates do not reach the range registers, while the code channel keeps working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and updates take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_span | input | 1 | Channel select: 0 = code channel, 1 = range channel |
| rd | input | 1 | Readback enable; blocks writes and updates |
| upd | input | 1 | Update request while `rd` is low; stage select while `rd` is high |
| wr_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Asynchronous active-low clear of the active code |
| man_span | input | 1 | Manual-range strap |
| strap_span | input | 3 | Fixed range used while `man_span` is high |
| data_in | input | 18 | Code port, inbound direction |
| data_out | output | 18 | Code port, readback direction |
| data_oe | output | 1 | Drive enable for `data_out` |
| span_in | input | 3 | Range port, inbound direction |
| span_out | output | 3 | Range port, readback direction |
| span_oe | output | 1 | Drive enable for `span_out` |
| dac_code | output | 18 | Active converter code |
| dac_span | output | 3 | Active output range |

## Verification
The assertions assume that every control input except `clr_n` is synchronous to `clk` and steady around the rising edge. They also assume that `clr_n` stays low long enough to span at least one edge when it is meant to load the register. The bench changes every input only on the falling edge, and holds each clear pulse low across a full cycle. The only exception is the directed step that lowers `clr_n` mid-cycle to show that the output changes without a clock. Random phases switch `man_span` only between cycles, so the strap check always compares against a strap value that has already settled.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int RANGE_W = 3;

  localparam logic [RANGE_W-1:0] RNG_U5   = 3'b000;
  localparam logic [RANGE_W-1:0] RNG_U10  = 3'b001;
  localparam logic [RANGE_W-1:0] RNG_B5   = 3'b010;
  localparam logic [RANGE_W-1:0] RNG_B10  = 3'b011;
  localparam logic [RANGE_W-1:0] RNG_B2P5 = 3'b100;
  localparam logic [RANGE_W-1:0] RNG_OFS  = 3'b101;

  typedef enum logic [1:0] {
    SC_ZERO    = 2'd0,
    SC_MID     = 2'd1,
    SC_QUARTER = 2'd2
  } clr_scale_e;

  function automatic clr_scale_e scale_of(input logic [RANGE_W-1:0] rng);
    case (rng)
      RNG_B5, RNG_B10, RNG_B2P5: scale_of = SC_MID;
      RNG_OFS:                   scale_of = SC_QUARTER;
      default:                   scale_of = SC_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/dac_regpair.sv
module dac_regpair #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         upd_en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] in_q,
  output logic [W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (rst)        in_q <= '0;
    else if (wr_en) in_q <= wr_val;
  end

  // the forced load wins over a transfer from the staging register
  always_ff @(posedge clk) begin
    if (rst)         act_q <= '0;
    else if (ld_en)  act_q <= ld_val;
    else if (upd_en) act_q <= in_q;
  end
endmodule

// File: rtl/dac_clrcode.sv
module dac_clrcode
  import dacif_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic [RANGE_W-1:0] rng,
  output logic [DATA_W-1:0]  code
);
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] QTR_CODE = DATA_W'(1) << (DATA_W - 2);

  always_comb begin
    case (scale_of(rng))
      SC_MID:     code = MID_CODE;
      SC_QUARTER: code = QTR_CODE;
      default:    code = '0;
    endcase
  end
endmodule

// File: rtl/dac_rdport.sv
module dac_rdport #(
  parameter int W = 18
) (
  input  logic         rd,
  input  logic         hit,
  input  logic         pick_act,
  input  logic [W-1:0] in_q,
  input  logic [W-1:0] act_q,
  output logic [W-1:0] q,
  output logic         oe
);
  assign oe = rd & hit;
  assign q  = !oe ? '0 : (pick_act ? act_q : in_q);
endmodule

// File: rtl/dac_regif.sv
module dac_regif
  import dacif_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_span,
  input  logic               rd,
  input  logic               upd,
  input  logic               wr_n,
  input  logic               clr_n,
  input  logic               man_span,
  input  logic [RANGE_W-1:0] strap_span,
  input  logic [DATA_W-1:0]  data_in,
  output logic [DATA_W-1:0]  data_out,
  output logic               data_oe,
  input  logic [RANGE_W-1:0] span_in,
  output logic [RANGE_W-1:0] span_out,
  output logic               span_oe,
  output logic [DATA_W-1:0]  dac_code,
  output logic [RANGE_W-1:0] dac_span
);
  logic [DATA_W-1:0]  code_in_q, code_act_q, clr_val;
  logic [RANGE_W-1:0] rng_in_q, rng_act_q, rng_live;
  logic               wr_ok, upd_ok, rng_ok;

  assign wr_ok  = ~wr_n & ~rd;
  assign upd_ok = upd & ~rd & clr_n;
  assign rng_ok = ~man_span;

  assign rng_live = man_span ? strap_span : rng_act_q;

  dac_clrcode #(.DATA_W(DATA_W)) u_clr (
    .rng  (rng_live),
    .code (clr_val)
  );

  dac_regpair #(.W(DATA_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok & ~sel_span),
    .wr_val (data_in),
    .upd_en (upd_ok),
    .ld_en  (~clr_n),
    .ld_val (clr_val),
    .in_q   (code_in_q),
    .act_q  (code_act_q)
  );

  dac_regpair #(.W(RANGE_W)) u_rng (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok & sel_span & rng_ok),
    .wr_val (span_in),
    .upd_en (upd_ok & rng_ok),
    .ld_en  (1'b0),
    .ld_val ('0),
    .in_q   (rng_in_q),
    .act_q  (rng_act_q)
  );

  dac_rdport #(.W(DATA_W)) u_rd_code (
    .rd       (rd),
    .hit      (~sel_span),
    .pick_act (upd),
    .in_q     (code_in_q),
    .act_q    (code_act_q),
    .q        (data_out),
    .oe       (data_oe)
  );

  dac_rdport #(.W(RANGE_W)) u_rd_rng (
    .rd       (rd),
    .hit      (sel_span & rng_ok),
    .pick_act (upd),
    .in_q     (rng_in_q),
    .act_q    (rng_act_q),
    .q        (span_out),
    .oe       (span_oe)
  );

  // the clear reaches the output without waiting for an edge
  assign dac_code = clr_n ? code_act_q : clr_val;
  assign dac_span = rng_live;
endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_span,
  input logic              rd,
  input logic              upd,
  input logic              clr_n,
  input logic              man_span,
  input logic [2:0]        strap_span,
  input logic              data_oe,
  input logic              span_oe,
  input logic [DATA_W-1:0] dac_code,
  input logic [2:0]        dac_span,
  input logic [DATA_W-1:0] code_in_q
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] QTR = DATA_W'(1) << (DATA_W - 2);

  assert_code_oe_R6: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (rd && !sel_span));

  assert_span_oe_R6: assert property (@(posedge clk) disable iff (rst)
    span_oe |-> (rd && sel_span && !man_span));

  assert_clear_value_R8: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (dac_code == '0 || dac_code == MID || dac_code == QTR));

  assert_rd_blocks_update_R7: assert property (@(posedge clk) disable iff (rst)
    (rd && clr_n) |=> (!clr_n || $stable(dac_code)));

  assert_update_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd && upd && clr_n) |=> (!clr_n || dac_code == $past(code_in_q)));

  assert_strap_range_R10: assert property (@(posedge clk) disable iff (rst)
    man_span |-> (dac_span == strap_span));
endmodule

bind dac_regif dac_regif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_span   (sel_span),
  .rd         (rd),
  .upd        (upd),
  .clr_n      (clr_n),
  .man_span   (man_span),
  .strap_span (strap_span),
  .data_oe    (data_oe),
  .span_oe    (span_oe),
  .dac_code   (dac_code),
  .dac_span   (dac_span),
  .code_in_q  (code_in_q)
);

// File: tb/dac_regif_test.sv
`timescale 1ns/1ps
module dac_regif_test;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_span = 1'b0, rd = 1'b0, upd = 1'b0, wr_n = 1'b1;
  logic          clr_n = 1'b1, man_span = 1'b0;
  logic [2:0]    strap_span = 3'b000, span_in = 3'b000;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out, dac_code;
  logic [2:0]    span_out, dac_span;
  logic          data_oe, span_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [DW-1:0] m_in_d = '0, m_act_d = '0;
  logic [2:0]    m_in_s = '0, m_act_s = '0;

  always #2 clk = ~clk;

  dac_regif #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .sel_span(sel_span), .rd(rd), .upd(upd),
    .wr_n(wr_n), .clr_n(clr_n), .man_span(man_span), .strap_span(strap_span),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .span_in(span_in), .span_out(span_out), .span_oe(span_oe),
    .dac_code(dac_code), .dac_span(dac_span)
  );

  function automatic logic [DW-1:0] clr_code(input logic [2:0] s);
    case (s)
      3'b010, 3'b011, 3'b100: clr_code = 18'h20000;
      3'b101:                 clr_code = 18'h10000;
      default:                clr_code = 18'h00000;
    endcase
  endfunction

  function automatic logic [2:0] live_span();
    live_span = man_span ? strap_span : m_act_s;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // one clock: the model follows the inputs held since the last falling edge
  task automatic tick();
    logic [DW-1:0] nd_in, nd_act;
    logic [2:0]    ns_in, ns_act;
    @(posedge clk);
    nd_in = m_in_d; nd_act = m_act_d; ns_in = m_in_s; ns_act = m_act_s;
    if (rst) begin
      nd_in = '0; nd_act = '0; ns_in = '0; ns_act = '0;
    end else begin
      if (!wr_n && !rd && !sel_span) nd_in = data_in;
      if (!wr_n && !rd && sel_span && !man_span) ns_in = span_in;
      if (!clr_n) nd_act = clr_code(live_span());
      else if (upd && !rd) begin
        nd_act = m_in_d;
        if (!man_span) ns_act = m_in_s;
      end
    end
    m_in_d = nd_in; m_act_d = nd_act; m_in_s = ns_in; m_act_s = ns_act;
    @(negedge clk);
  endtask

  task automatic check_model(input string req);
    chk(req, 32'(dac_code), 32'(clr_n ? m_act_d : clr_code(live_span())));
    chk(req, 32'(dac_span), 32'(live_span()));
    chk(req, 32'(data_oe), 32'(rd & ~sel_span));
    chk(req, 32'(span_oe), 32'(rd & sel_span & ~man_span));
    if (data_oe) chk(req, 32'(data_out), 32'(upd ? m_act_d : m_in_d));
    if (span_oe) chk(req, 32'(span_out), 32'(upd ? m_act_s : m_in_s));
  endtask

  task automatic idle();
    rd = 0; upd = 0; wr_n = 1; clr_n = 1;
  endtask

  task automatic wr_code(input logic [DW-1:0] v);
    idle(); sel_span = 0; wr_n = 0; data_in = v; tick(); idle();
  endtask

  task automatic wr_rng(input logic [2:0] v);
    idle(); sel_span = 1; wr_n = 0; span_in = v; tick(); idle();
  endtask

  task automatic do_upd();
    idle(); upd = 1; tick(); idle();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick(); rst = 0;
    // R1: state after reset
    chk("R1", 32'(dac_code), 0); chk("R1", 32'(dac_span), 0);
    chk("R1", 32'(data_oe), 0);  chk("R1", 32'(span_oe), 0);

    wr_code(18'h2A5A5);
    chk("R2", 32'(dac_code), 0);
    rd = 1; sel_span = 0; upd = 0; #0.5;
    chk("R2", 32'(data_out), 32'h2A5A5);
    chk("R6", 32'(data_oe), 1); chk("R6", 32'(span_oe), 0);
    idle();

    wr_rng(3'b011);
    chk("R3", 32'(dac_span), 0);
    rd = 1; sel_span = 1; upd = 0; #0.5;
    chk("R3", 32'(span_out), 3); chk("R6", 32'(data_oe), 0);
    idle();

    // R4: write while reading
    rd = 1; sel_span = 0; wr_n = 0; data_in = 18'h11111; tick();
    wr_n = 1; #0.5;
    chk("R4", 32'(data_out), 32'h2A5A5);
    idle();

    sel_span = 1; do_upd();
    chk("R5", 32'(dac_code), 32'h2A5A5); chk("R5", 32'(dac_span), 3);

    wr_code(18'h00123);
    rd = 1; upd = 1; sel_span = 0; tick();
    chk("R7", 32'(dac_code), 32'h2A5A5);
    chk("R6", 32'(data_out), 32'h2A5A5);
    upd = 0; #0.5;
    chk("R6", 32'(data_out), 32'h00123);
    idle();

    // R8: mid-cycle clear, no edge needed
    #0.5 clr_n = 0; #0.5;
    chk("R8", 32'(dac_code), 32'h20000);
    wr_rng(3'b101);
    // R9: clear held across an update request
    clr_n = 0; upd = 1; tick(); idle();
    chk("R9", 32'(dac_code), 32'h20000); chk("R9", 32'(dac_span), 3);
    rd = 1; sel_span = 0; #0.5;
    chk("R8", 32'(data_out), 32'h00123);
    idle();

    for (int s = 0; s < 8; s++) begin
      wr_rng(3'(s)); do_upd();
      clr_n = 0; tick(); clr_n = 1; #0.5;
      chk("R8", 32'(dac_code), 32'(clr_code(3'(s))));
    end

    // R10: manual range strap
    wr_rng(3'b010); do_upd();
    man_span = 1; strap_span = 3'b101; #0.5;
    chk("R10", 32'(dac_span), 5);
    rd = 1; sel_span = 1; #0.5;
    chk("R10", 32'(span_oe), 0);
    idle();
    clr_n = 0; #0.5;
    chk("R10", 32'(dac_code), 32'h10000);
    idle();
    wr_rng(3'b100); wr_code(18'h3FFFF); do_upd();
    chk("R10", 32'(dac_code), 32'h3FFFF);
    man_span = 0; #0.5;
    chk("R10", 32'(dac_span), 2);
    rd = 1; sel_span = 1; #0.5;
    chk("R10", 32'(span_out), 2);
    idle();

    // constrained random traffic against the reference state
    void'($urandom(32'd2757));
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        man_span = $urandom_range(0, 1);
        strap_span = 3'($urandom_range(0, 7));
      end
      sel_span = $urandom_range(0, 1);
      rd       = ($urandom_range(0, 9) < 3);
      upd      = ($urandom_range(0, 9) < 3);
      wr_n     = ($urandom_range(0, 1) == 0);
      clr_n    = ($urandom_range(0, 9) != 0);
      data_in  = 18'($urandom);
      span_in  = 3'($urandom_range(0, 7));
      #0.5;
      check_model("R6");
      tick();
      check_model("R5 R8 R9");
    end
    summary();
  end
endmodule